// File: doc/BRIEF.md
# SPI Master Character Transmitter

This block is a serial-peripheral master that sends 8-bit characters, most significant bit first, with clock phase 0 and a selectable clock polarity. Software-side logic drops one character at a time into a single holding register. When the shift path is idle, that character moves into the shift register, which frees the holding register for the next one. Every character is framed by its own slave-select pulse. Guard bit-times before and after the character keep consecutive frames clearly apart.

Two status outputs describe the transmit side. `tx_ready` means the holding register can take a character. `tx_empty` means nothing is queued and nothing is being shifted. The receive side is reduced to one capture register: MISO is sampled on each leading clock edge, and a full byte raises `rx_ready`, which a read strobe clears. An optional gate holds each new character back until the last received byte has been read, so incoming data is never overwritten. Two command pulses let the host pin slave select low across many characters and later let it go. The bit-time is a whole number of system clocks, set by a half-period divider input.

Top module: `spi_char_tx`

## Requirements
- R1: After reset with `tx_en` high, `ss_n` is 1, `sck` equals `cpol`, `rx_ready` is 0, and both `tx_ready` and `tx_empty` are 1.
- R2: A write (`wr_stb` high while `tx_ready` is 1) drops `tx_ready` in the next cycle. If no character is being shifted, the character enters the shift register one clock later, `tx_ready` returns to 1 and `ss_n` falls.
- R3: `tx_empty` is 1 only when the holding register is empty and no frame is in progress. With a second character queued, it stays 0 from the first write until the second frame has fully ended.
- R4: A write presented while `tx_ready` is 0 is discarded, and that character never appears on `mosi`.
- R5: While `tx_en` is 0, `tx_ready` and `tx_empty` are both 0, writes are discarded and no frame starts.
- R6: With `wait_rd` at 1, a queued character does not start while `rx_ready` is 1, and it starts after `rd_stb` clears `rx_ready`. With `wait_rd` at 0, it starts regardless of `rx_ready`.
- R7: The first leading `sck` edge comes 1.5 bit-times after `ss_n` falls. `ss_n` rises one bit-time after the last trailing `sck` edge. When the next character is already waiting, `ss_n` stays high for one bit-time plus one clock before it falls again.
- R8: A `force_sel` pulse holds `ss_n` at 0 across any number of frames. Only a `release_sel` pulse returns `ss_n` to 1 outside a frame. If both pulses arrive in the same cycle, release wins.
- R9: Each frame carries 8 bits on `mosi`, MSB first. Each bit is already present half a bit-time before its leading edge. `sck` rests at the `cpol` level, and the leading edge is the move away from `cpol`. `sck` only leaves `cpol` while `ss_n` is 0.
- R10: `miso` is sampled on each of the 8 leading edges, MSB first. After the frame, `rd_data` holds that byte and `rx_ready` is 1. A `rd_stb` pulse clears `rx_ready`, and nothing else clears it.
- R11: One bit-time is `2*half_div` clocks, and consecutive leading `sck` edges are exactly that far apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable; low clears the queue and cancels a frame |
| cpol | input | 1 | Serial clock rest level |
| wait_rd | input | 1 | Hold each character until the receive byte has been read |
| half_div | input | DIV_W | System clocks per serial clock half-period (at least 1) |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| force_sel | input | 1 | Command pulse: hold slave select low |
| release_sel | input | 1 | Command pulse: free slave select |
| rd_stb | input | 1 | Read strobe for the receive byte |
| miso | input | 1 | Serial data from the slave |
| tx_ready | output | 1 | Holding register can accept a character |
| tx_empty | output | 1 | Queue and shifter both idle |
| rx_ready | output | 1 | A received byte is waiting |
| rd_data | output | 8 | Last received byte |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |

## Verification
A phase counter that drifts by one half-period would move the leading `sck` edges relative to `ss_n`. The lead time, the trail time or the edge spacing would then differ from the expected count within the first frame. A shifter loaded or advanced on the wrong edge shows up as a wrong byte at the slave model as soon as that frame completes, and a wrong receive capture shows up on `rd_data` right after it. Queue or gating faults change how many frames appear, or whether `ss_n` falls, within a few dozen clocks of the write or read strobe.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;

    localparam int CHAR_W       = 8;
    localparam int GUARD_HALVES = 2;
    localparam int DATA_HALVES  = 2 * CHAR_W;
    localparam int HC_W         = $clog2(DATA_HALVES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_GAP
    } phase_t;

    typedef struct packed {
        logic              full;
        logic [CHAR_W-1:0] data;
    } hold_t;

    typedef struct packed {
        logic              valid;
        logic [CHAR_W-1:0] data;
    } rx_word_t;

    // Number of serial half-periods spent in each phase.
    function automatic int phase_halves(phase_t p);
        case (p)
            ST_SHIFT: return DATA_HALVES;
            default:  return GUARD_HALVES;
        endcase
    endfunction

    function automatic phase_t phase_next(phase_t p);
        case (p)
            ST_LEAD:  return ST_SHIFT;
            ST_SHIFT: return ST_TRAIL;
            ST_TRAIL: return ST_GAP;
            default:  return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             half_tick
);

    logic [DIV_W-1:0] dcnt;
    logic             at_end;

    assign at_end    = (dcnt == half_div - 1'b1);
    assign half_tick = run && at_end;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            dcnt <= '0;
        end else if (at_end) begin
            dcnt <= '0;
        end else begin
            dcnt <= dcnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi_tx_hold.sv
module spi_tx_hold
    import spi_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              wr_stb,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              take,
    output hold_t             hold
);

    logic accept;

    assign accept = en && wr_stb && !hold.full;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hold.full <= 1'b0;
            hold.data <= '0;
        end else if (take) begin
            hold.full <= 1'b0;
        end else if (accept) begin
            hold.full <= 1'b1;
            hold.data <= wr_data;
        end
    end

endmodule

// File: rtl/spi_rx_hold.sv
module spi_rx_hold
    import spi_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     done,
    input  logic [CHAR_W-1:0] byte_in,
    input  logic     rd_stb,
    output rx_word_t word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (done) begin
            word.valid <= 1'b1;
            word.data  <= byte_in;
        end else if (rd_stb) begin
            word.valid <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              half_tick,
    input  logic              start,
    input  logic [CHAR_W-1:0] load_data,
    input  logic              miso,
    output logic              busy,
    output logic              frame_act,
    output logic              sck_act,
    output logic              mosi_bit,
    output logic              rx_done,
    output logic [CHAR_W-1:0] rx_byte
);

    phase_t            st;
    logic [HC_W-1:0]   hc;
    logic [CHAR_W-1:0] tx_sh;
    logic [CHAR_W-1:0] rx_sh;
    logic              last_half;

    assign busy      = (st != ST_IDLE);
    assign frame_act = (st == ST_LEAD) || (st == ST_SHIFT) || (st == ST_TRAIL);
    assign mosi_bit  = tx_sh[CHAR_W-1];
    assign rx_byte   = rx_sh;
    assign last_half = (int'(hc) == phase_halves(st) - 1);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st      <= ST_IDLE;
            hc      <= '0;
            sck_act <= 1'b0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_done <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            if (st == ST_IDLE) begin
                if (start) begin
                    tx_sh <= load_data;
                    hc    <= '0;
                    st    <= ST_LEAD;
                end
            end else if (half_tick) begin
                if (st == ST_SHIFT) begin
                    if (!hc[0]) begin
                        // leading edge: capture the incoming bit
                        sck_act <= 1'b1;
                        rx_sh   <= {rx_sh[CHAR_W-2:0], miso};
                        if (int'(hc) == DATA_HALVES - 2) begin
                            rx_done <= 1'b1;
                        end
                    end else begin
                        // trailing edge: present the next bit
                        sck_act <= 1'b0;
                        tx_sh   <= {tx_sh[CHAR_W-2:0], 1'b0};
                    end
                end
                if (last_half) begin
                    hc <= '0;
                    st <= phase_next(st);
                end else begin
                    hc <= hc + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_char_tx.sv
module spi_char_tx
    import spi_tx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              cpol,
    input  logic              wait_rd,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              wr_stb,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              force_sel,
    input  logic              release_sel,
    input  logic              rd_stb,
    input  logic              miso,
    output logic              tx_ready,
    output logic              tx_empty,
    output logic              rx_ready,
    output logic [CHAR_W-1:0] rd_data,
    output logic              sck,
    output logic              mosi,
    output logic              ss_n
);

    hold_t             hold;
    rx_word_t          rx_word;
    logic              start;
    logic              busy;
    logic              frame_act;
    logic              sck_act;
    logic              mosi_bit;
    logic              rx_done;
    logic [CHAR_W-1:0] rx_byte;
    logic              half_tick;
    logic              sel_forced;

    assign start = tx_en && hold.full && !busy && (!wait_rd || !rx_word.valid);

    spi_tx_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .en      (tx_en),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (start),
        .hold    (hold)
    );

    spi_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .half_div  (half_div),
        .half_tick (half_tick)
    );

    spi_frame_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en        (tx_en),
        .half_tick (half_tick),
        .start     (start),
        .load_data (hold.data),
        .miso      (miso),
        .busy      (busy),
        .frame_act (frame_act),
        .sck_act   (sck_act),
        .mosi_bit  (mosi_bit),
        .rx_done   (rx_done),
        .rx_byte   (rx_byte)
    );

    spi_rx_hold u_rx (
        .clk     (clk),
        .rst     (rst),
        .done    (rx_done),
        .byte_in (rx_byte),
        .rd_stb  (rd_stb),
        .word    (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_forced <= 1'b0;
        end else if (release_sel) begin
            sel_forced <= 1'b0;
        end else if (force_sel) begin
            sel_forced <= 1'b1;
        end
    end

    assign tx_ready = tx_en && !hold.full;
    assign tx_empty = tx_en && !hold.full && !busy;
    assign rx_ready = rx_word.valid;
    assign rd_data  = rx_word.data;
    assign sck      = cpol ^ sck_act;
    assign mosi     = frame_act ? mosi_bit : 1'b1;
    assign ss_n     = !(frame_act || sel_forced);

endmodule

// File: rtl/spi_char_tx_chk.sv
module spi_char_tx_chk (
    input logic clk,
    input logic rst,
    input logic cpol,
    input logic wait_rd,
    input logic wr_stb,
    input logic force_sel,
    input logic release_sel,
    input logic rd_stb,
    input logic tx_ready,
    input logic tx_empty,
    input logic rx_ready,
    input logic sck,
    input logic ss_n
);

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && tx_ready) |=> !tx_ready); // R2

    AST_EMPTY_NO_CLOCK: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> (sck == cpol)); // R3

    AST_WAIT_GATE: assert property (@(posedge clk) disable iff (rst)
        ($fell(ss_n) && $past(wait_rd) && !$past(force_sel)) |-> !$past(rx_ready)); // R6

    AST_RELEASE_WINS: assert property (@(posedge clk) disable iff (rst)
        (release_sel && tx_empty) |=> ss_n); // R8

    AST_CLOCK_FRAMED: assert property (@(posedge clk) disable iff (rst)
        (sck != cpol) |-> !ss_n); // R9

    AST_RX_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_ready) |-> $past(rd_stb)); // R10

endmodule

bind spi_char_tx spi_char_tx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cpol        (cpol),
    .wait_rd     (wait_rd),
    .wr_stb      (wr_stb),
    .force_sel   (force_sel),
    .release_sel (release_sel),
    .rd_stb      (rd_stb),
    .tx_ready    (tx_ready),
    .tx_empty    (tx_empty),
    .rx_ready    (rx_ready),
    .sck         (sck),
    .ss_n        (ss_n)
);

// File: tb/spi_char_tx_tb.sv
module spi_char_tx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;
    localparam int NVEC       = 6;
    // {cpol, half_div[3:0], tx byte, miso byte}
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b0, 4'd2, 8'hA5, 8'h3C},
        {1'b1, 4'd2, 8'h5A, 8'hC3},
        {1'b0, 4'd1, 8'h80, 8'h01},
        {1'b1, 4'd3, 8'h01, 8'h80},
        {1'b0, 4'd4, 8'hFF, 8'h00},
        {1'b1, 4'd1, 8'h00, 8'hFF}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tx_en = 1'b1;
    logic             cpol = 1'b0;
    logic             wait_rd = 1'b0;
    logic [DIV_W-1:0] half_div = 8'd2;
    logic             wr_stb = 1'b0;
    logic [7:0]       wr_data = '0;
    logic             force_sel = 1'b0;
    logic             release_sel = 1'b0;
    logic             rd_stb = 1'b0;
    logic             miso = 1'b0;
    logic             tx_ready, tx_empty, rx_ready, sck, mosi, ss_n;
    logic [7:0]       rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // slave model state
    int         cyc = 0;
    logic [7:0] pat = 8'h00;
    logic [7:0] shreg = '0;
    logic [7:0] last_byte = '0;
    int         nbit = 0;
    int         frames = 0;
    int         ss_rises = 0;
    int         t_fall = 0, t_rise = 0, t_prev_lead = 0, t_last_trail = 0;
    int         lead_t = 0, trail_t = 0, period = 0, last_gap = 0;
    bit         seen_rise = 0;
    logic       prev_ss = 1'b1, prev_sck = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_char_tx #(.DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .cpol(cpol), .wait_rd(wait_rd),
        .half_div(half_div), .wr_stb(wr_stb), .wr_data(wr_data),
        .force_sel(force_sel), .release_sel(release_sel), .rd_stb(rd_stb),
        .miso(miso), .tx_ready(tx_ready), .tx_empty(tx_empty),
        .rx_ready(rx_ready), .rd_data(rd_data), .sck(sck), .mosi(mosi),
        .ss_n(ss_n)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Slave model and watchdog, sampled between clock edges.
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (prev_ss && !ss_n) begin
                if (seen_rise) last_gap = cyc - t_rise;
                t_fall = cyc;
                nbit   = 0;
                miso   = pat[7];
            end
            if (!prev_ss && ss_n) begin
                t_rise    = cyc;
                seen_rise = 1;
                ss_rises++;
                trail_t   = cyc - t_last_trail;
            end
            if (!ss_n && sck != prev_sck) begin
                if (sck != cpol) begin
                    if (nbit == 0) lead_t = cyc - t_fall;
                    else           period = cyc - t_prev_lead;
                    t_prev_lead = cyc;
                    shreg = {shreg[6:0], mosi};
                    nbit++;
                    if (nbit == 8) begin
                        frames++;
                        last_byte = shreg;
                    end
                end else begin
                    t_last_trail = cyc;
                    if (nbit >= 8) begin
                        nbit = 0;
                        miso = pat[7];
                    end else begin
                        miso = pat[7-nbit];
                    end
                end
            end
        end
        prev_ss  = ss_n;
        prev_sck = sck;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL R1 watchdog act=%0d exp<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_char(input logic [7:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 4000 && !tx_empty; i++) @(negedge clk);
    endtask

    initial begin
        int fb, rb;
        tick(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ss_n", ss_n, 1);
        chk("R1 sck", sck, 0);
        chk("R1 rx_ready", rx_ready, 0);
        chk("R1 tx_ready", tx_ready, 1);
        chk("R1 tx_empty", tx_empty, 1);

        // Vector table: R9 R10 R11 R7
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            cpol     = VEC[v][20];
            half_div = DIV_W'(VEC[v][19:16]);
            pat      = VEC[v][7:0];
            tick(2);
            chk("R9 idle level", sck, int'(cpol));
            fb = frames;
            write_char(VEC[v][15:8]);
            wait_empty();
            tick(1);
            chk("R9 frame count", frames, fb + 1);
            chk("R9 mosi byte", last_byte, VEC[v][15:8]);
            chk("R10 rd_data", rd_data, VEC[v][7:0]);
            chk("R10 rx_ready set", rx_ready, 1);
            chk("R11 edge spacing", period, 2 * int'(half_div));
            chk("R7 lead time", lead_t, 3 * int'(half_div));
            chk("R7 trail time", trail_t, 2 * int'(half_div));
            pulse_rd();
            chk("R10 rx_ready cleared", rx_ready, 0);
        end

        cpol = 1'b0;
        half_div = 8'd2;
        pat = 8'h96;

        // R2 / R3: queue two characters
        fb = frames;
        write_char(8'h11);
        chk("R2 tx_ready after write", tx_ready, 0);
        @(negedge clk);
        chk("R2 tx_ready after move", tx_ready, 1);
        chk("R2 ss_n low", ss_n, 0);
        write_char(8'h22);
        chk("R3 tx_empty low", tx_empty, 0);
        rb = ss_rises;
        for (int i = 0; i < 4000 && ss_rises == rb; i++) @(negedge clk);
        chk("R3 tx_empty between frames", tx_empty, 0);
        wait_empty();
        tick(1);
        chk("R3 two frames", frames, fb + 2);
        chk("R3 second byte", last_byte, 8'h22);
        chk("R7 select gap", last_gap, 2 * 2 + 1);
        pulse_rd();

        // R4: write while not ready is lost
        fb = frames;
        @(negedge clk);
        wr_stb = 1'b1; wr_data = 8'h33;
        @(negedge clk);
        chk("R4 not ready", tx_ready, 0);
        wr_data = 8'h44;
        @(negedge clk);
        wr_stb = 1'b0;
        wait_empty();
        tick(4);
        chk("R4 single frame", frames, fb + 1);
        chk("R4 byte kept", last_byte, 8'h33);
        chk("R4 stays empty", tx_empty, 1);
        pulse_rd();

        // R5: disabled
        @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk("R5 tx_ready off", tx_ready, 0);
        chk("R5 tx_empty off", tx_empty, 0);
        fb = frames;
        write_char(8'h55);
        tick(20);
        chk("R5 no select", ss_n, 1);
        tx_en = 1'b1;
        tick(20);
        chk("R5 write dropped", frames, fb);
        chk("R5 empty again", tx_empty, 1);

        // R6: wait-for-read gate
        fb = frames;
        write_char(8'h66);
        wait_empty();
        tick(1);
        chk("R6 rx_ready before gate", rx_ready, 1);
        wait_rd = 1'b1;
        write_char(8'h77);
        tick(30);
        chk("R6 held select", ss_n, 1);
        chk("R6 held frames", frames, fb + 1);
        pulse_rd();
        wait_empty();
        tick(1);
        chk("R6 released frame", frames, fb + 2);
        chk("R6 released byte", last_byte, 8'h77);
        wait_rd = 1'b0;
        write_char(8'h78);
        wait_empty();
        tick(1);
        chk("R6 no gate", frames, fb + 3);
        pulse_rd();

        // R8: forced select
        fb = frames;
        @(negedge clk);
        force_sel = 1'b1;
        @(negedge clk);
        force_sel = 1'b0;
        chk("R8 forced low", ss_n, 0);
        rb = ss_rises;
        write_char(8'h81);
        tick(3);
        write_char(8'h82);
        wait_empty();
        tick(3);
        chk("R8 no release", ss_rises, rb);
        chk("R8 frames", frames, fb + 2);
        chk("R8 byte", last_byte, 8'h82);
        chk("R8 still low", ss_n, 0);
        @(negedge clk);
        release_sel = 1'b1;
        @(negedge clk);
        release_sel = 1'b0;
        chk("R8 released", ss_n, 1);
        @(negedge clk);
        force_sel = 1'b1;
        release_sel = 1'b1;
        @(negedge clk);
        force_sel = 1'b0;
        release_sel = 1'b0;
        chk("R8 release wins", ss_n, 1);

        done = 1;
        summary();
        $finish;
    end

endmodule